// File: doc/BRIEF.md
# Buffer-Slaved Serial Transmitter with End-of-Frame Idle Run

This block serializes bytes handed to it one at a time by a buffer manager. The manager raises a data-valid strobe with a byte and a flag marking the final byte of a frame. The transmitter takes the byte only when it is idle. It sends the byte as a standard asynchronous character and returns a one-cycle acknowledge only once the stop bit has left the line. The manager then moves on to the next byte.

After the final byte of a frame, the line is held high for a programmable number of bit periods as an end-of-frame marker. Only then is a one-cycle frame-complete pulse raised. Because of this ordering, firmware may start the next frame as soon as it sees completion. Bit timing comes from a programmable divider plus a per-character stretch value that lengthens the first few bits of each character by one clock.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset, `tx_out` is 1 and `byte_ack` and `frame_done` are 0.
- R2: Each character is sent as one start bit at 0, then the eight bits of the byte with bit 0 first, then one stop bit at 1.
- R3: A bit lasts `baud_div`+1 clock cycles. Number the bits of a character 0 (start) through 9 (stop). A bit whose number is below `baud_corr` lasts one cycle longer.
- R4: A byte is accepted at a clock edge where the block is idle, `data_valid` is 1 and `byte_ack` is 0. `tx_out` goes to 0 in the cycle after that edge. The byte and the last flag are captured at acceptance, and later changes on `data_byte` have no effect on the character being sent.
- R5: `byte_ack` is 1 for exactly one cycle: the cycle right after the final cycle of the stop bit. `data_valid` is ignored during that cycle, so `tx_out` stays 1 through the following cycle.
- R6: After the stop bit of a byte flagged last, `tx_out` stays 1 for `eof_len`×(`baud_div`+1) cycles, with no stretch, and `frame_done` stays 0 during that run.
- R7: `frame_done` is a one-cycle pulse in the cycle right after the end-of-frame run. When `eof_len` is 0, it coincides with the `byte_ack` of the last byte.
- R8: When `eof_len` is nonzero, a byte offered during the `frame_done` cycle is accepted at the next edge.
- R9: A byte not flagged last produces no `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Bit period minus one, in clock cycles |
| baud_corr | input | CORR_W | Number of leading bits per character stretched by one cycle |
| eof_len | input | EOF_W | Number of idle bit periods after the last byte |
| data_valid | input | 1 | Buffer manager offers a byte |
| data_byte | input | 8 | Offered byte |
| data_last | input | 1 | Offered byte ends the frame |
| byte_ack | output | 1 | One-cycle pulse after the stop bit is sent |
| frame_done | output | 1 | One-cycle pulse after the end-of-frame run |
| tx_out | output | 1 | Serial line, idle high |

## Verification
The bench builds the block with its default widths: a 12-bit divider, a 4-bit stretch field and a 6-bit end-of-frame length. It drives divider values from 0 upward, so single-cycle bits and multi-cycle bits are both covered. Stretch values of 0, partial, exactly 10 and above 10 reach every bit-number boundary of R3. End-of-frame lengths of 0 and nonzero exercise both completion orderings, and a nonzero length also gives the done cycle in which the next frame may start.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DIV_W  = 12,
  parameter int CORR_W = 4,
  parameter int EOF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [CORR_W-1:0] baud_corr,
  input  logic [EOF_W-1:0]  eof_len,
  input  logic              data_valid,
  input  logic [7:0]        data_byte,
  input  logic              data_last,
  output logic              byte_ack,
  output logic              frame_done,
  output logic              tx_out
);

  localparam int CW = DIV_W + 1;
  localparam int IW = (CORR_W > 4) ? CORR_W : 4;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_EOF} st_t;

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [3:0]       idx;
  logic [7:0]       shreg;
  logic             last_q;
  logic [EOF_W-1:0] eof_left;

  function automatic logic [CW-1:0] bit_len(input logic [3:0] i);
    logic stretch;
    stretch = IW'(i) < IW'(baud_corr);
    return {1'b0, baud_div} + {{DIV_W{1'b0}}, stretch};
  endfunction

  assign tx_out = (state == S_START) ? 1'b0 :
                  (state == S_DATA)  ? shreg[0] : 1'b1;

  wire bit_end = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      idx        <= '0;
      shreg      <= '0;
      last_q     <= 1'b0;
      eof_left   <= '0;
      byte_ack   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      byte_ack   <= 1'b0;
      frame_done <= 1'b0;
      case (state)
        S_IDLE: if (data_valid && !byte_ack) begin
          shreg  <= data_byte;
          last_q <= data_last;
          idx    <= 4'd0;
          cnt    <= bit_len(4'd0);
          state  <= S_START;
        end
        S_START, S_DATA: begin
          if (!bit_end) cnt <= cnt - 1'b1;
          else begin
            idx <= idx + 4'd1;
            cnt <= bit_len(idx + 4'd1);
            if (state == S_DATA) shreg <= shreg >> 1;
            state <= (idx == 4'd8) ? S_STOP : S_DATA;
          end
        end
        S_STOP: begin
          if (!bit_end) cnt <= cnt - 1'b1;
          else begin
            byte_ack <= 1'b1;
            if (last_q && eof_len != '0) begin
              state    <= S_EOF;
              eof_left <= eof_len;
              cnt      <= {1'b0, baud_div};
            end else begin
              state      <= S_IDLE;
              frame_done <= last_q;
            end
          end
        end
        S_EOF: begin
          if (!bit_end) cnt <= cnt - 1'b1;
          else if (eof_left == EOF_W'(1)) begin
            state      <= S_IDLE;
            frame_done <= 1'b1;
          end else begin
            eof_left <= eof_left - 1'b1;
            cnt      <= {1'b0, baud_div};
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && data_valid && !byte_ack) |=> !tx_out);

  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ack |=> !byte_ack);

  assert_ack_line_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ack |-> tx_out);

  assert_ack_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ack |=> tx_out);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (byte_ack || $past(state) == S_EOF));

  assert_eof_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EOF) |-> (tx_out && !frame_done));

endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] baud_div = '0;
  logic [3:0]  baud_corr = '0;
  logic [5:0]  eof_len = '0;
  logic        data_valid = 1'b0;
  logic [7:0]  data_byte = '0;
  logic        data_last = 1'b0;
  logic        byte_ack, frame_done, tx_out;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  uart_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .baud_corr(baud_corr),
    .eof_len(eof_len), .data_valid(data_valid), .data_byte(data_byte),
    .data_last(data_last), .byte_ack(byte_ack), .frame_done(frame_done),
    .tx_out(tx_out)
  );

  // {byte[30:23], last[22], div[21:10], corr[9:6], eof[5:0]}
  localparam int NV = 7;
  localparam logic [30:0] VEC [NV] = '{
    {8'hA5, 1'b1, 12'd3, 4'd0,  6'd0},
    {8'h3C, 1'b0, 12'd2, 4'd3,  6'd2},
    {8'hF0, 1'b1, 12'd2, 4'd3,  6'd2},
    {8'h01, 1'b0, 12'd0, 4'd0,  6'd1},
    {8'h80, 1'b1, 12'd0, 4'd10, 6'd3},
    {8'h5A, 1'b1, 12'd5, 4'd15, 6'd1},
    {8'hC3, 1'b1, 12'd1, 4'd9,  6'd4}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; offers the byte there and follows it to its end.
  task automatic send(input logic [7:0] b, input logic lst, input logic [11:0] dv,
                      input logic [3:0] cr, input logic [5:0] eo);
    baud_div = dv; baud_corr = cr; eof_len = eo;
    data_valid = 1'b1; data_byte = b; data_last = lst;
    @(negedge clk);
    data_byte = ~b; // R4: must not affect the character
    for (int bi = 0; bi < 10; bi++) begin
      logic expb;
      int p;
      int bad;
      int badv;
      expb = (bi == 0) ? 1'b0 : (bi == 9) ? 1'b1 : b[bi-1];
      p = int'(dv) + 1 + ((bi < int'(cr)) ? 1 : 0);
      bad = 0; badv = expb;
      for (int c = 0; c < p; c++) begin
        if (tx_out !== expb || byte_ack !== 1'b0) begin bad = 1; badv = tx_out; end
        @(negedge clk);
      end
      chk(bad == 0, "R2/R3 bit", badv, expb);
    end
    chk(byte_ack === 1'b1, "R5 ack after stop", byte_ack, 1);
    data_valid = 1'b0;
    if (!lst) chk(frame_done === 1'b0, "R9 no done mid-frame", frame_done, 0);
    else if (eo == 0) chk(frame_done === 1'b1, "R7 done with ack", frame_done, 1);
    else begin
      int bad;
      bad = 0;
      for (int k = 0; k < int'(eo) * (int'(dv) + 1); k++) begin
        if (frame_done !== 1'b0 || tx_out !== 1'b1) bad = 1;
        @(negedge clk);
      end
      chk(bad == 0, "R6 eof run high", bad, 0);
      chk(frame_done === 1'b1, "R7 done after eof", frame_done, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_out === 1'b1, "R1 tx idle", tx_out, 1);
    chk(byte_ack === 1'b0 && frame_done === 1'b0, "R1 pulses low", byte_ack, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][30:23], VEC[v][22], VEC[v][21:10], VEC[v][9:6], VEC[v][5:0]);
      @(negedge clk);
      chk(byte_ack === 1'b0 && frame_done === 1'b0, "R5/R7 single pulse",
          byte_ack | frame_done, 0);
    end

    // R8: new frame offered in the done cycle starts at once
    send(8'h96, 1'b1, 12'd1, 4'd2, 6'd2);
    send(8'h69, 1'b1, 12'd1, 4'd2, 6'd0);
    @(negedge clk);

    // R5: valid held through the ack cycle is ignored there
    send(8'h11, 1'b0, 12'd1, 4'd0, 6'd0);
    data_valid = 1'b1; data_byte = 8'h22; data_last = 1'b1;
    @(negedge clk);
    chk(tx_out === 1'b1, "R5 ignored during ack", tx_out, 1);
    @(negedge clk);
    chk(tx_out === 1'b0, "R4 start after ack", tx_out, 0);
    data_valid = 1'b0;
    for (int k = 0; k < 100 && frame_done !== 1'b1; k++) @(negedge clk);
    chk(frame_done === 1'b1, "R7 done for held byte", frame_done, 1);

    // R1: reset mid-character returns the line to idle
    @(negedge clk);
    data_valid = 1'b1; data_byte = 8'h00; data_last = 1'b0; baud_div = 12'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b0; data_valid = 1'b0;
    @(negedge clk);
    chk(tx_out === 1'b1 && byte_ack === 1'b0, "R1 reset mid-byte", tx_out, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule